// File: doc/BRIEF.md
# USB Device Function Address Register

This block holds the bus address that a USB device function answers to. Software writes a new 7-bit address through a small register port: an offset, a write strobe and 8 bits of write data, with 8 bits of read data back. A written address does not go live at once. It is parked as pending. The device keeps answering to its previous address until the control transfer in progress finishes, which is normally at the end of the status stage of the set-address request. A read-only flag in the top bit of the register tells software whether the last write is still waiting to take effect.

The protocol logic elsewhere sends a single-cycle transfer-complete pulse. On that pulse the pending address becomes the active address. The block also compares the active address with the address field of each incoming token and drives a match output. A detected bus reset input returns everything to address zero.

Top module: `usb_func_addr_reg`

## Requirements
- R1: After the active-low synchronous reset, the register reads 0x00 and a valid token carrying address 0x00 matches.
- R2: A write to the register offset (default 0) stores write data bits 6:0 as the last written address and sets the update flag. The register reads back {update flag in bit 7, last written address in bits 6:0}, and write data bit 7 is ignored.
- R3: While a write is pending, the active address is unchanged, so tokens still match the old address.
- R4: A transfer-complete pulse while the update flag is 1 makes the pending address active from the next cycle and clears the update flag in that same cycle.
- R5: When several writes happen before a transfer completes, only the most recent written value becomes active.
- R6: A transfer-complete pulse while the update flag is 0 leaves the active address and the register contents unchanged.
- R7: An asserted bus reset clears the active address, the pending address and the update flag in one cycle. It takes priority over a write in the same cycle.
- R8: The token match output is 1 only when the token valid input is 1 and the token address equals the active address. A pending address never produces a match.
- R9: Writes at any other offset have no effect, and reads at any other offset return 0x00.
- R10: When a write and a transfer-complete pulse arrive in the same cycle with a write already pending, the earlier pending value becomes active. The new value becomes pending and the update flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_addr | input | 4 | Register offset for both read and write |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 8 | Write data; bits 6:0 are the new address |
| cfg_rdata | output | 8 | Read data: update flag in bit 7, last written address in bits 6:0 |
| bus_reset | input | 1 | Detected bus reset, one or more cycles |
| xfer_done | input | 1 | Pulse marking the end of the current transfer |
| tok_valid | input | 1 | Token address qualifier |
| tok_addr | input | 7 | Address field of the incoming token |
| tok_match | output | 1 | Token address equals the active address |

## Verification
The register is driven with a single write followed by a completion, with two writes before one completion, with a completion when nothing is pending, and with a write and a completion in the same cycle. Each of these leads to a different pair of active and readback values. In each case, probing the token comparator with both the old and the new address separates a commit that happens too early, too late, or with the wrong value. Writes and reads at a foreign offset, writes with data bit 7 set, and a bus reset that coincides with a write show whether decode, field masking and reset priority hold.

// File: rtl/usb_fa_pkg.sv
// Package: shared widths and the register image type for the function
// address register. Assumes a 7-bit USB function address.
package usb_fa_pkg;

    localparam int FA_W  = 7;
    localparam int REG_W = FA_W + 1;

    typedef struct packed {
        logic            upd;   // 1: last written address not yet active
        logic [FA_W-1:0] addr;  // last written address
    } fa_image_t;

endpackage

// File: rtl/fa_reg_port.sv
// Module: fa_reg_port
// Decodes the register offset for writes and builds the read data.
// Assumes single-cycle write strobes and a purely combinational read.
module fa_reg_port
    import usb_fa_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int REG_OFFSET = 0
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  fa_image_t         image,
    output logic              wr_hit,
    output logic [FA_W-1:0]   wr_addr,
    output logic [REG_W-1:0]  cfg_rdata
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    logic sel;

    // Offset decode shared by reads and writes.
    always_comb begin
        sel = (cfg_addr == OFFS);
    end

    // Write qualification and masking of the read-only bit.
    always_comb begin
        wr_hit  = cfg_wr && sel;
        wr_addr = cfg_wdata[FA_W-1:0];
    end

    // Read mux: the register image at its offset, zero elsewhere.
    always_comb begin
        cfg_rdata = sel ? REG_W'(image) : '0;
    end

endmodule

// File: rtl/fa_commit_ctrl.sv
// Module: fa_commit_ctrl
// Holds the pending and active function address and the update flag.
// A write parks the address as pending; a transfer-complete pulse
// with a write pending makes it active. Bus reset wins over all else.
// Assumes xfer_done is a one-cycle pulse per finished transfer.
module fa_commit_ctrl
    import usb_fa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            wr_hit,
    input  logic [FA_W-1:0] wr_addr,
    input  logic            xfer_done,
    output logic [FA_W-1:0] act_addr,
    output logic [FA_W-1:0] pend_addr,
    output logic            upd_flag
);

    logic commit;

    // A commit needs both a finished transfer and a pending write.
    always_comb begin
        commit = xfer_done && upd_flag;
    end

    // Active address: loads the pending value on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            act_addr <= '0;
        end else if (commit) begin
            act_addr <= pend_addr;
        end
    end

    // Pending address: the most recent value software wrote.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            pend_addr <= '0;
        end else if (wr_hit) begin
            pend_addr <= wr_addr;
        end
    end

    // Update flag: set by a write, cleared by a commit with no new write.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            upd_flag <= 1'b0;
        end else if (wr_hit) begin
            upd_flag <= 1'b1;
        end else if (commit) begin
            upd_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/fa_token_cmp.sv
// Module: fa_token_cmp
// Compares a token's address field with the active function address.
// Assumes tok_addr is stable while tok_valid is high.
module fa_token_cmp
    import usb_fa_pkg::*;
(
    input  logic            tok_valid,
    input  logic [FA_W-1:0] tok_addr,
    input  logic [FA_W-1:0] act_addr,
    output logic            tok_match
);

    // Qualified equality against the active address only.
    always_comb begin
        tok_match = tok_valid && (tok_addr == act_addr);
    end

endmodule

// File: rtl/usb_func_addr_reg.sv
// Module: usb_func_addr_reg (top)
// USB device function address register with deferred commit, a
// readable pending flag and a token address comparator.
// Assumes a synchronous active-low reset and single-cycle strobes.
module usb_func_addr_reg
    import usb_fa_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int REG_OFFSET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              bus_reset,
    input  logic              xfer_done,
    input  logic              tok_valid,
    input  logic [6:0]        tok_addr,
    output logic              tok_match
);

    logic            wr_hit;
    logic [FA_W-1:0] wr_addr;
    logic [FA_W-1:0] act_addr;
    logic [FA_W-1:0] pend_addr;
    logic            upd_flag;
    fa_image_t       image;

    // Register image seen by software.
    always_comb begin
        image.upd  = upd_flag;
        image.addr = pend_addr;
    end

    fa_reg_port #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_port (
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .image     (image),
        .wr_hit    (wr_hit),
        .wr_addr   (wr_addr),
        .cfg_rdata (cfg_rdata)
    );

    fa_commit_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_hit    (wr_hit),
        .wr_addr   (wr_addr),
        .xfer_done (xfer_done),
        .act_addr  (act_addr),
        .pend_addr (pend_addr),
        .upd_flag  (upd_flag)
    );

    fa_token_cmp u_cmp (
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .act_addr  (act_addr),
        .tok_match (tok_match)
    );

endmodule

// File: rtl/usb_func_addr_reg_chk.sv
// Module: usb_func_addr_reg_chk
// Property checker for usb_func_addr_reg, attached by bind.
module usb_func_addr_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_reset,
    input logic       xfer_done,
    input logic       wr_hit,
    input logic [7:0] cfg_wdata,
    input logic       tok_valid,
    input logic [6:0] tok_addr,
    input logic       tok_match,
    input logic [6:0] act_addr,
    input logic [6:0] pend_addr,
    input logic       upd_flag
);

    p_wr_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !bus_reset) |=> (upd_flag && pend_addr == $past(cfg_wdata[6:0])));

    p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && !(xfer_done && upd_flag)) |=> (act_addr == $past(act_addr)));

    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && xfer_done && upd_flag && !wr_hit)
            |=> (!upd_flag && act_addr == $past(pend_addr)));

    p_bus_reset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (act_addr == 7'd0 && pend_addr == 7'd0 && !upd_flag));

    p_match_active_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tok_match |-> (tok_valid && tok_addr == act_addr));

    p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && xfer_done && upd_flag && wr_hit)
            |=> (upd_flag && act_addr == $past(pend_addr)));

endmodule

bind usb_func_addr_reg usb_func_addr_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .xfer_done (xfer_done),
    .wr_hit    (wr_hit),
    .cfg_wdata (cfg_wdata),
    .tok_valid (tok_valid),
    .tok_addr  (tok_addr),
    .tok_match (tok_match),
    .act_addr  (act_addr),
    .pend_addr (pend_addr),
    .upd_flag  (upd_flag)
);

// File: tb/usb_func_addr_reg_tb.sv
// Bench: behavioural queue model compared every clock, plus directed
// checks with literal expected values.
module usb_func_addr_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       bus_reset = 1'b0;
    logic       xfer_done = 1'b0;
    logic       tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic       tok_match;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_run = 1'b0;

    // Reference model state.
    int m_active = 0;
    int m_last = 0;
    int m_pend_q[$];

    always #10 clk = ~clk;

    usb_func_addr_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_reset(bus_reset),
        .xfer_done(xfer_done), .tok_valid(tok_valid), .tok_addr(tok_addr),
        .tok_match(tok_match)
    );

    // Model update on each edge, from the inputs held over the cycle.
    always @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            m_active = 0;
            m_last = 0;
            m_pend_q.delete();
        end else begin
            if (xfer_done && m_pend_q.size() > 0) m_active = m_pend_q.pop_front();
            if (cfg_wr && cfg_addr == 4'd0) begin
                m_pend_q.delete();
                m_pend_q.push_back(cfg_wdata % 128);
                m_last = cfg_wdata % 128;
            end
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        int exp_rd;
        int exp_m;
        if (rst_n && !done_run) begin
            exp_rd = (cfg_addr != 4'd0) ? 0 :
                     ((m_pend_q.size() > 0) ? 128 : 0) + m_last;
            exp_m = (tok_valid && int'(tok_addr) == m_active) ? 1 : 0;
            checks++;
            if (int'(cfg_rdata) != exp_rd) begin
                errors++;
                $display("FAIL R2 model readback: got %02h expected %02h", cfg_rdata, exp_rd);
            end
            checks++;
            if (int'(tok_match) != exp_m) begin
                errors++;
                $display("FAIL R8 model match: got %0d expected %0d", tok_match, exp_m);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One-cycle stimulus step.
    task automatic step(input bit wr, input logic [3:0] off, input logic [7:0] d,
                        input bit dn, input bit br);
        @(posedge clk); #2;
        cfg_wr = wr; cfg_addr = off; cfg_wdata = d; xfer_done = dn; bus_reset = br;
        @(posedge clk); #2;
        cfg_wr = 1'b0; cfg_addr = 4'd0; xfer_done = 1'b0; bus_reset = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] d);
        step(1'b1, 4'd0, d, 1'b0, 1'b0);
    endtask

    task automatic xfer_end();
        step(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Present a token and sample the match away from the edge.
    task automatic probe(input logic [6:0] a, input bit v, input string req, input int exp);
        tok_addr = a; tok_valid = v;
        @(negedge clk); #1;
        chk(req, int'(tok_match), exp);
        tok_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, input string req, input int exp);
        cfg_addr = off;
        @(negedge clk); #1;
        chk(req, int'(cfg_rdata), exp);
        cfg_addr = 4'd0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, "R1 reset readback", 'h00);
        probe(7'h00, 1'b1, "R1 reset match addr 0", 1);
        // R2 write sets flag; bit 7 of data ignored
        wr_reg(8'h13);
        rd(4'd0, "R2 readback after write", 'h93);
        // R3 old address still active, R8 pending never matches
        probe(7'h00, 1'b1, "R3 old address still matches", 1);
        probe(7'h13, 1'b1, "R8 pending address no match", 0);
        // R4 commit on transfer end
        xfer_end();
        rd(4'd0, "R4 flag cleared after commit", 'h13);
        probe(7'h13, 1'b1, "R4 new address matches", 1);
        probe(7'h00, 1'b1, "R4 old address dropped", 0);
        // R6 completion with nothing pending
        xfer_end();
        rd(4'd0, "R6 readback unchanged", 'h13);
        probe(7'h13, 1'b1, "R6 active unchanged", 1);
        // R5 two writes, last wins; data bit 7 set is ignored
        wr_reg(8'h21);
        wr_reg(8'hC2);
        rd(4'd0, "R5 readback last write", 'hC2);
        probe(7'h13, 1'b1, "R3 still old before commit", 1);
        xfer_end();
        probe(7'h42, 1'b1, "R5 last write active", 1);
        probe(7'h21, 1'b1, "R5 first write not active", 0);
        // R9 foreign offset
        step(1'b1, 4'd1, 8'h55, 1'b0, 1'b0);
        rd(4'd0, "R9 foreign write ignored", 'h42);
        probe(7'h42, 1'b1, "R9 active kept", 1);
        rd(4'd1, "R9 foreign read zero", 'h00);
        // R8 valid qualifier
        probe(7'h42, 1'b0, "R8 no match without valid", 0);
        // R10 write and completion together
        wr_reg(8'h10);
        step(1'b1, 4'd0, 8'h11, 1'b1, 1'b0);
        probe(7'h10, 1'b1, "R10 earlier pending active", 1);
        rd(4'd0, "R10 new value pending", 'h91);
        xfer_end();
        probe(7'h11, 1'b1, "R10 second commit", 1);
        // R7 bus reset with write in same cycle
        step(1'b1, 4'd0, 8'h7F, 1'b0, 1'b1);
        rd(4'd0, "R7 reset beats write", 'h00);
        probe(7'h00, 1'b1, "R7 address zero active", 1);
        wr_reg(8'h30);
        step(1'b0, 4'd0, 8'h00, 1'b0, 1'b1);
        rd(4'd0, "R7 pending cleared", 'h00);
        xfer_end();
        probe(7'h30, 1'b1, "R7 no commit after reset", 0);
        probe(7'h00, 1'b1, "R7 zero still active", 1);
        repeat (2) @(posedge clk);
        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule